// File: doc/BRIEF.md
# Calendar Time-Keeping Update Engine

This block keeps wall-clock time and the calendar (seconds, minutes, hours, day of week, day of month, month, two-digit year and a century byte) and advances them once per second. The one-second event comes from a countdown chain that counts oscillator-tick strobes. All bytes are held in either packed BCD or plain binary, and hours use either a 24-hour or a 12-hour format with a PM flag. Month lengths, leap years and an optional daylight-saving shift are applied as part of each step.

Two copies of the time exist. An internal copy always advances. A user-visible copy follows it on every update, but it freezes while a hold input is high, so software can load or read a consistent set of bytes. When the hold drops, the user copy takes the internal value at once, so no second is lost. A warning flag rises a fixed number of oscillator ticks before each transfer. An update-ended pulse and an alarm-match pulse mark each step. Bytes are loaded through a simple select/data write port, which writes both copies.

Top module: `rtc_tod_engine`

## Requirements
- R1: After reset the user copy reads seconds, minutes, hours, year and century as 00, and day of week, date and month as 01. The warning flag, update pulse and alarm pulse are all 0.
- R2: The divider code works as follows. With `dv_ctl` = 010 the chain counts oscillator ticks and updates once every `DIV_TICKS` ticks. With `dv_ctl[2:1]` = 11 the chain is held in reset, and the first update comes `DIV_TICKS/2` ticks after 010 is applied. Any other code stops the chain, so no update occurs.
- R3: Each update adds one second and carries 59 seconds to the minutes, 59 minutes to the hours, and hour 23 (with `hr24` = 1, hours 0 to 23) to the next day at hour 0.
- R4: With `hr24` = 0, bit 7 of the hours byte is the PM flag and the hour value runs 1 to 12. 11:59:59 goes to 12:00:00 with the flag toggled. 12:59:59 goes to 1:00:00 with the flag kept. 11:59:59 PM starts a new day at 12 AM.
- R5: With `bin_mode` = 1 every time, calendar and alarm byte is plain binary. With `bin_mode` = 0 every byte is packed BCD (tens digit in bits 7:4).
- R6: At a new day the day of week steps 1 to 7 and wraps from 7 to 1. The date wraps to 1 after the month's last day: 30 days for months 4, 6, 9 and 11; 29 days for month 2 when the year is a multiple of 4, otherwise 28; 31 days for all other months. Month 12 wraps to 1 and advances the year.
- R7: When the year wraps from 99 to 00, the century byte's low seven bits become BCD 20 (0x20) and its bit 7 keeps its written value.
- R8: While `set_hold` is 1 the user copy does not change except by writes, and the internal copy keeps advancing. In the cycle after `set_hold` falls, the user copy equals the internal time.
- R9: `uip_o` is 1 during the last `WARN_TICKS` oscillator ticks before each update while the chain runs and `set_hold` is 0. It is 0 while `set_hold` is 1.
- R10: `upd_pulse_o` is high for exactly one clock after every update, including updates made while `set_hold` is 1.
- R11: On each update the new hours, minutes and seconds are compared with the three alarm bytes. An alarm byte with bits 7:6 = 11 matches any value. A full match raises `alarm_o` for the same one clock as `upd_pulse_o`.
- R12: With `dst_en` = 1, on a Sunday (day of week 1) in month 4 with date 1 to 7, time 01:59:59 steps to 03:00:00.
- R13: With `dst_en` = 1, on a Sunday in month 10 with date 25 to 31, the first 01:59:59 steps back to 01:00:00. A later 01:59:59 on that day steps on to 02:00:00. The fall-back is re-armed at the next midnight rollover and by reset.
- R14: `wr_sel` codes 0 to 7 write seconds, minutes, hours, day of week, date, month, year and century. A write updates both copies. Bit 7 of the seconds byte is read-only and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| dv_ctl | input | 3 | Divider control code |
| set_hold | input | 1 | Freeze user copy, block transfers |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enable daylight-saving shifts |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Byte selector for writes |
| wr_data | input | 8 | Byte write data |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| sec_o | output | 8 | User copy: seconds |
| min_o | output | 8 | User copy: minutes |
| hr_o | output | 8 | User copy: hours |
| dow_o | output | 8 | User copy: day of week |
| date_o | output | 8 | User copy: day of month |
| mon_o | output | 8 | User copy: month |
| yr_o | output | 8 | User copy: year |
| cent_o | output | 8 | User copy: century |
| uip_o | output | 1 | Update-imminent warning |
| upd_pulse_o | output | 1 | One-clock pulse after each update |
| alarm_o | output | 1 | One-clock alarm match pulse |

## Verification
Some properties are checked on every cycle. The alarm pulse never appears without an update pulse, and the update pulse lasts a single clock. Every unheld update was preceded by the warning flag and moves the seconds byte. The user copy stays frozen while the hold is kept. Calendar arithmetic can only be shown through the bench scenarios. These cover hour sweeps in both formats and both encodings, month and leap-year ends, the century wrap, daylight-saving jumps including the once-per-day fall-back, the divider's half-second start, and the value seen when the hold is released.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } tod_t;

    localparam tod_t TOD_RESET = '{cent: 8'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                   dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HR   = 3'd2,
        SEL_DOW  = 3'd3,
        SEL_DATE = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YR   = 3'd6,
        SEL_CENT = 3'd7
    } sel_e;

    // Stored byte to binary value
    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic bin);
        return bin ? v : ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
    endfunction

    // Binary value to stored byte
    function automatic logic [7:0] to_enc(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bin ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] y);
        case (mo)
            8'd2:                       return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
            default:                    return 8'd31;
        endcase
    endfunction

    function automatic tod_t put_byte(input tod_t t, input logic [2:0] sel, input logic [7:0] v);
        tod_t r;
        r = t;
        case (sel_e'(sel))
            SEL_SEC:  r.sec  = {1'b0, v[6:0]};
            SEL_MIN:  r.min  = v;
            SEL_HR:   r.hr   = v;
            SEL_DOW:  r.dow  = v;
            SEL_DATE: r.date = v;
            SEL_MON:  r.mon  = v;
            SEL_YR:   r.yr   = v;
            default:  r.cent = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int DIV_TICKS  = 32768,
    parameter int WARN_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [2:0] dv_ctl,
    input  logic       set_hold,
    output logic       upd_stb,
    output logic       uip
);
    localparam int CW = $clog2(DIV_TICKS);
    localparam logic [CW-1:0] LAST    = CW'(DIV_TICKS - 1);
    localparam logic [CW-1:0] HALF    = CW'(DIV_TICKS / 2);
    localparam logic [CW-1:0] WARN_AT = CW'(DIV_TICKS - WARN_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t div_d, div_q;
    logic    run;

    always_comb begin
        div_d   = div_q;
        upd_stb = 1'b0;
        run     = (dv_ctl == 3'b010);
        if (dv_ctl[2:1] == 2'b11) begin
            div_d.cnt = HALF;
        end else if (run && osc_tick) begin
            if (div_q.cnt == LAST) begin
                div_d.cnt = '0;
                upd_stb   = 1'b1;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
        uip = run && (div_q.cnt >= WARN_AT) && !set_hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q.cnt <= HALF;
        else        div_q     <= div_d;
    end
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_tod_pkg::*;
(
    input  tod_t cur,
    input  logic bin_mode,
    input  logic hr24,
    input  logic dst_en,
    input  logic armed,
    output tod_t nxt,
    output logic fall_taken,
    output logic new_day
);
    logic [7:0] s, m, h, h12, dw, dt, mo, y, mlen, ho, ho_enc, cent_n;
    logic       at_edge, spring, pm;

    always_comb begin
        h12 = '0;
        s   = to_bin(cur.sec & 8'h7F, bin_mode);
        m   = to_bin(cur.min, bin_mode);
        if (hr24) begin
            h = to_bin(cur.hr & 8'h3F, bin_mode);
        end else begin
            h12 = to_bin(cur.hr & 8'h1F, bin_mode);
            h   = ((h12 == 8'd12) ? 8'd0 : h12) + (cur.hr[7] ? 8'd12 : 8'd0);
        end
        dw     = cur.dow & 8'h07;
        dt     = to_bin(cur.date, bin_mode);
        mo     = to_bin(cur.mon, bin_mode);
        y      = to_bin(cur.yr, bin_mode);
        mlen   = month_len(mo, y);
        cent_n = cur.cent;

        at_edge    = dst_en && (dw == 8'd1) && (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
        spring     = at_edge && (mo == 8'd4) && (dt <= 8'd7);
        fall_taken = at_edge && (mo == 8'd10) && (dt >= 8'd25) && armed;
        new_day    = 1'b0;

        if (spring) begin
            s = 8'd0; m = 8'd0; h = 8'd3;
        end else if (fall_taken) begin
            s = 8'd0; m = 8'd0; h = 8'd1;
        end else if (s != 8'd59) begin
            s = s + 8'd1;
        end else begin
            s = 8'd0;
            if (m != 8'd59) m = m + 8'd1;
            else begin
                m = 8'd0;
                if (h != 8'd23) h = h + 8'd1;
                else begin
                    h       = 8'd0;
                    new_day = 1'b1;
                end
            end
        end

        if (new_day) begin
            dw = (dw == 8'd7) ? 8'd1 : dw + 8'd1;
            if (dt != mlen) dt = dt + 8'd1;
            else begin
                dt = 8'd1;
                if (mo != 8'd12) mo = mo + 8'd1;
                else begin
                    mo = 8'd1;
                    if (y != 8'd99) y = y + 8'd1;
                    else begin
                        y      = 8'd0;
                        cent_n = {cur.cent[7], 7'h20};
                    end
                end
            end
        end

        pm     = (h >= 8'd12);
        ho     = (h % 8'd12 == 8'd0) ? 8'd12 : h % 8'd12;
        ho_enc = to_enc(ho, bin_mode);

        nxt.sec  = to_enc(s, bin_mode);
        nxt.min  = to_enc(m, bin_mode);
        nxt.hr   = hr24 ? to_enc(h, bin_mode) : {pm, ho_enc[6:0]};
        nxt.dow  = dw;
        nxt.date = to_enc(dt, bin_mode);
        nxt.mon  = to_enc(mo, bin_mode);
        nxt.yr   = to_enc(y, bin_mode);
        nxt.cent = cent_n;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int NBYTES = 3
) (
    input  logic [NBYTES-1:0][7:0] now_b,
    input  logic [NBYTES-1:0][7:0] alm_b,
    output logic                   hit
);
    logic [NBYTES-1:0] lane_ok;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign lane_ok[i] = (alm_b[i][7:6] == 2'b11) || (alm_b[i] == now_b[i]);
    end

    assign hit = &lane_ok;
endmodule

// File: rtl/rtc_tod_engine.sv
module rtc_tod_engine
    import rtc_tod_pkg::*;
#(
    parameter int DIV_TICKS  = 32768,
    parameter int WARN_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [2:0] dv_ctl,
    input  logic       set_hold,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] mon_o,
    output logic [7:0] yr_o,
    output logic [7:0] cent_o,
    output logic       uip_o,
    output logic       upd_pulse_o,
    output logic       alarm_o
);
    typedef struct packed {
        tod_t tod;
        tod_t usr;
        logic armed;
        logic set_q;
        logic upd;
        logic alm;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic    stb, hit, fall_taken, new_day;
    tod_t    nxt;

    rtc_tick_div #(.DIV_TICKS(DIV_TICKS), .WARN_TICKS(WARN_TICKS)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .dv_ctl(dv_ctl),
        .set_hold(set_hold), .upd_stb(stb), .uip(uip_o)
    );

    rtc_cal_step u_step (
        .cur(st_q.tod), .bin_mode(bin_mode), .hr24(hr24), .dst_en(dst_en),
        .armed(st_q.armed), .nxt(nxt), .fall_taken(fall_taken), .new_day(new_day)
    );

    rtc_alarm_match #(.NBYTES(3)) u_alm (
        .now_b({nxt.hr, nxt.min, nxt.sec}),
        .alm_b({alm_hr, alm_min, alm_sec}),
        .hit(hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.set_q = set_hold;
        st_d.upd   = stb;
        st_d.alm   = stb && hit;
        if (stb) begin
            st_d.tod = nxt;
            if (fall_taken)   st_d.armed = 1'b0;
            else if (new_day) st_d.armed = 1'b1;
            if (!set_hold)    st_d.usr   = nxt;
        end else if (st_q.set_q && !set_hold) begin
            st_d.usr = st_q.tod;
        end
        if (wr_en) begin
            st_d.tod = put_byte(st_d.tod, wr_sel, wr_data);
            st_d.usr = put_byte(st_d.usr, wr_sel, wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tod   <= TOD_RESET;
            st_q.usr   <= TOD_RESET;
            st_q.armed <= 1'b1;
            st_q.set_q <= 1'b0;
            st_q.upd   <= 1'b0;
            st_q.alm   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o       = st_q.usr.sec;
    assign min_o       = st_q.usr.min;
    assign hr_o        = st_q.usr.hr;
    assign dow_o       = st_q.usr.dow;
    assign date_o      = st_q.usr.date;
    assign mon_o       = st_q.usr.mon;
    assign yr_o        = st_q.usr.yr;
    assign cent_o      = st_q.usr.cent;
    assign upd_pulse_o = st_q.upd;
    assign alarm_o     = st_q.alm;
endmodule

// File: rtl/rtc_tod_engine_chk.sv
module rtc_tod_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_hold,
    input logic       wr_en,
    input logic       uip_o,
    input logic       upd_pulse_o,
    input logic       alarm_o,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hr_o
);
    // R11
    alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> upd_pulse_o);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |=> !upd_pulse_o);

    // R8
    frozen_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && $past(set_hold) && !$past(wr_en))
        |-> ($stable(sec_o) && $stable(min_o) && $stable(hr_o)));

    // R9
    warned_before_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse_o && !$past(set_hold)) |-> $past(uip_o));

    // R3
    second_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse_o && !$past(set_hold) && !$past(wr_en)) |-> (sec_o != $past(sec_o)));
endmodule

bind rtc_tod_engine rtc_tod_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .set_hold(set_hold), .wr_en(wr_en),
    .uip_o(uip_o), .upd_pulse_o(upd_pulse_o), .alarm_o(alarm_o),
    .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o)
);

// File: tb/rtc_tod_engine_test.sv
module rtc_tod_engine_test;
    localparam int DIV  = 16;
    localparam int WARN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic [2:0] dv_ctl = 3'b110;
    logic       set_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       hr24 = 1'b1;
    logic       dst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic [7:0] sec_o, min_o, hr_o, dow_o, date_o, mon_o, yr_o, cent_o;
    logic       uip_o, upd_pulse_o, alarm_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    rtc_tod_engine #(.DIV_TICKS(DIV), .WARN_TICKS(WARN)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .dv_ctl(dv_ctl),
        .set_hold(set_hold), .bin_mode(bin_mode), .hr24(hr24), .dst_en(dst_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .dow_o(dow_o), .date_o(date_o),
        .mon_o(mon_o), .yr_o(yr_o), .cent_o(cent_o),
        .uip_o(uip_o), .upd_pulse_o(upd_pulse_o), .alarm_o(alarm_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] e(input int v);
        return bin_mode ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        wr_sel = s; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] s, mi, h, dw, dt, mo, y, c);
        dv_ctl = 3'b110;
        set_hold = 1'b1;
        @(negedge clk);
        wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
        wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y); wr(3'd7, c);
        set_hold = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_upd(output int n, output int u);
        n = 0; u = 0;
        do begin
            @(negedge clk);
            n++;
            if (uip_o) u++;
        end while (!upd_pulse_o && n < 100);
    endtask

    task automatic step();
        int n, u;
        dv_ctl = 3'b010;
        wait_upd(n, u);
        if (!upd_pulse_o) chk("R2 update missing", 0, 1);
    endtask

    function automatic logic [7:0] hb12(input int h);
        int v;
        v = (h % 12 == 0) ? 12 : h % 12;
        return {(h >= 12) ? 1'b1 : 1'b0, e(v)[6:0]};
    endfunction

    initial begin
        int n, u, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sec", sec_o, 8'h00);  chk("R1 hr", hr_o, 8'h00);
        chk("R1 dow", dow_o, 8'h01);  chk("R1 date", date_o, 8'h01);
        chk("R1 mon", mon_o, 8'h01);  chk("R1 cent", cent_o, 8'h00);
        chk("R1 uip", uip_o, 0);      chk("R1 upd", upd_pulse_o, 0);
        chk("R1 alarm", alarm_o, 0);

        // R14 seconds bit 7 read-only, write visible in user copy
        wr(3'd0, 8'hD5);
        chk("R14 sec mask", sec_o, 8'h55);
        wr(3'd6, 8'h42);
        chk("R14 year write", yr_o, 8'h42);

        // R2 / R9 divider timing and warning
        load(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20, 8'h20);
        dv_ctl = 3'b010;
        wait_upd(n, u);
        chk("R2 first update half period", n, DIV / 2);
        chk("R9 warn ticks first", u, WARN);
        wait_upd(n, u);
        chk("R2 full period", n, DIV);
        chk("R9 warn ticks", u, WARN);
        chk("R3 seconds after two", sec_o, 8'h02);
        dv_ctl = 3'b000;
        cnt = 0;
        repeat (40) begin @(negedge clk); if (upd_pulse_o) cnt++; end
        chk("R2 stopped code no update", cnt, 0);
        chk("R2 stopped seconds held", sec_o, 8'h02);

        // R8 / R10 / R9 hold behaviour
        load(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h20, 8'h20);
        set_hold = 1'b1;
        dv_ctl = 3'b010;
        wait_upd(n, u);
        chk("R10 pulse while held", upd_pulse_o, 1);
        chk("R9 no warn while held", u, 0);
        chk("R8 frozen sec", sec_o, 8'h00);
        wait_upd(n, u);
        chk("R10 period while held", n, DIV);
        chk("R8 frozen sec 2", sec_o, 8'h00);
        set_hold = 1'b0;
        @(negedge clk);
        chk("R8 transfer on release", sec_o, 8'h02);

        // R3 / R5 24-hour sweep, BCD and binary
        hr24 = 1'b1;
        for (int b = 0; b < 2; b++) begin
            bin_mode = b[0];
            for (int h = 0; h < 24; h++) begin
                load(e(59), e(59), e(h), 8'h03, e(10), e(5), e(24), 8'h20);
                step();
                chk($sformatf("R3 R5 hr h=%0d b=%0d", h, b), hr_o, e((h + 1) % 24));
                chk("R3 min", min_o, 8'h00);
                chk("R3 sec", sec_o, 8'h00);
                chk("R3 date", date_o, e(h == 23 ? 11 : 10));
            end
        end

        // R4 12-hour sweep, both encodings
        hr24 = 1'b0;
        for (int b = 0; b < 2; b++) begin
            bin_mode = b[0];
            for (int h = 0; h < 24; h++) begin
                load(e(59), e(59), hb12(h), 8'h03, e(10), e(5), e(24), 8'h20);
                step();
                chk($sformatf("R4 hr h=%0d b=%0d", h, b), hr_o, hb12((h + 1) % 24));
                chk("R4 date", date_o, e(h == 23 ? 11 : 10));
            end
        end
        hr24 = 1'b1;

        // R6 month ends and leap years
        for (int b = 0; b < 2; b++) begin
            bin_mode = b[0];
            for (int y = 23; y < 25; y++) begin
                for (int mo = 1; mo < 13; mo++) begin
                    load(e(59), e(59), e(23), 8'h07, e(mdays(mo, y)), e(mo), e(y), 8'h20);
                    step();
                    chk($sformatf("R6 date m=%0d y=%0d", mo, y), date_o, e(1));
                    chk("R6 mon", mon_o, e(mo % 12 + 1));
                    chk("R6 dow wrap", dow_o, 8'h01);
                    chk("R6 year", yr_o, e(mo == 12 ? y + 1 : y));
                end
                load(e(59), e(59), e(23), 8'h02, e(28), e(2), e(y), 8'h20);
                step();
                chk($sformatf("R6 feb28 y=%0d", y), date_o, e(y % 4 == 0 ? 29 : 1));
                chk("R6 dow step", dow_o, 8'h03);
            end
        end
        bin_mode = 1'b0;

        // R7 century
        load(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99, 8'h99);
        step();
        chk("R7 year wrap", yr_o, 8'h00);
        chk("R7 century msb kept", cent_o, 8'hA0);
        load(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99, 8'h19);
        step();
        chk("R7 century load", cent_o, 8'h20);

        // R11 alarm
        alm_hr = 8'h05; alm_min = 8'h06; alm_sec = 8'h07;
        load(8'h06, 8'h06, 8'h05, 8'h02, 8'h01, 8'h03, 8'h24, 8'h20);
        step();
        chk("R11 exact match", alarm_o, 1);
        alm_sec = 8'h08;
        load(8'h06, 8'h06, 8'h05, 8'h02, 8'h01, 8'h03, 8'h24, 8'h20);
        step();
        chk("R11 mismatch", alarm_o, 0);
        alm_hr = 8'hFF; alm_min = 8'hC3; alm_sec = 8'h07;
        load(8'h06, 8'h33, 8'h17, 8'h02, 8'h01, 8'h03, 8'h24, 8'h20);
        step();
        chk("R11 wildcard hr min", alarm_o, 1);
        alm_hr = 8'h05; alm_min = 8'hC0; alm_sec = 8'h20;
        load(8'h19, 8'h41, 8'h06, 8'h02, 8'h01, 8'h03, 8'h24, 8'h20);
        step();
        chk("R11 wildcard min only", alarm_o, 0);
        load(8'h19, 8'h41, 8'h05, 8'h02, 8'h01, 8'h03, 8'h24, 8'h20);
        step();
        chk("R11 wildcard hit", alarm_o, 1);
        alm_hr = 8'h00; alm_min = 8'h00; alm_sec = 8'h00;

        // R12 spring forward
        dst_en = 1'b1;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h22, 8'h20);
        step();
        chk("R12 spring hr", hr_o, 8'h03);
        chk("R12 spring min", min_o, 8'h00);
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h08, 8'h04, 8'h22, 8'h20);
        step();
        chk("R12 second sunday no jump", hr_o, 8'h02);
        dst_en = 1'b0;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h03, 8'h04, 8'h22, 8'h20);
        step();
        chk("R12 disabled no jump", hr_o, 8'h02);

        // R13 fall back once per day
        dst_en = 1'b1;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h24, 8'h20);
        step();
        chk("R13 fall back hr", hr_o, 8'h01);
        chk("R13 fall back min", min_o, 8'h00);
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h24, 8'h20);
        step();
        chk("R13 second pass no repeat", hr_o, 8'h02);
        load(8'h59, 8'h59, 8'h23, 8'h01, 8'h27, 8'h10, 8'h24, 8'h20);
        step();
        chk("R13 midnight dow", dow_o, 8'h02);
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h24, 8'h20);
        step();
        chk("R13 rearmed after midnight", hr_o, 8'h01);
        dst_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule